// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block gives the fetch stage a predicted next PC in the same cycle the fetch PC is presented. It holds a direct-mapped table of 2^IDX_W slots, indexed by the word-address bits of the PC just above the two byte-offset bits. Each slot keeps a valid flag, the complete PC of the control-transfer instruction that owns it, a predicted target and a small saturating direction counter. The lookup reports a hit only when the slot is valid and its stored PC equals the fetch PC in every bit. When the counter says taken, the lookup redirects fetch to the stored target. In every other case the next PC is the fetch PC plus 4.

After a branch or jump resolves, the pipeline presents one update per cycle. The update carries the instruction PC, a control-transfer flag, the resolved direction and target, and a mispredict flag. Updates for non-control instructions are dropped. A resolved-taken control instruction that misses allocates its slot and overwrites whatever was there. A not-taken miss leaves the table alone. A hit always retrains the counter. Its target is rewritten only when the update is taken and flagged as mispredicted.

The whole PC is stored as the tag, so an ordinary instruction that shares a slot with a branch can never cause a false redirect.

Top module: `btb_top`

## Requirements
- R1: After reset, every slot is invalid, so every lookup gives pred_hit_o=0, pred_taken_o=0 and pred_npc_o = fetch PC + 4.
- R2: A lookup that hits a slot whose counter MSB is 1 (taken) gives pred_taken_o=1 and pred_npc_o = the stored target, in the same cycle.
- R3: A lookup whose slot is invalid, or whose stored PC differs from the fetch PC in any bit (including an alias with the same index bits PC[IDX_W+1:2]), gives pred_hit_o=0 and pred_npc_o = fetch PC + 4.
- R4: A lookup that hits a slot whose counter MSB is 0 gives pred_hit_o=1, pred_taken_o=0 and pred_npc_o = fetch PC + 4.
- R5: An update with upd_is_ctrl_i=0 changes no slot.
- R6: A control update that misses and resolves taken writes its PC, its target and the counter value 2'b10 (weak taken) into the slot. The entry is visible from the next cycle.
- R7: A control update that misses and resolves not-taken allocates nothing.
- R8: A control update that hits moves the 2-bit counter (00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken) one step toward the resolved direction and saturates at 00 and 11.
- R9: A control update that hits, resolves taken and has upd_mispredict_i=1 replaces the stored target with upd_target_i.
- R10: A control update that hits with upd_mispredict_i=0 leaves the stored target unchanged and changes only the counter.
- R11: An allocation overwrites the slot's previous owner. From the next cycle that owner misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | PC_W | Fetch PC to look up |
| pred_npc_o | output | PC_W | Predicted next fetch PC |
| pred_hit_o | output | 1 | Slot valid and stored PC equals fetch PC |
| pred_taken_o | output | 1 | Hit with counter predicting taken |
| upd_valid_i | input | 1 | Update fields are valid this cycle |
| upd_pc_i | input | PC_W | PC of the resolved instruction |
| upd_is_ctrl_i | input | 1 | Resolved instruction is a branch or jump |
| upd_taken_i | input | 1 | Resolved direction |
| upd_target_i | input | PC_W | Resolved target |
| upd_mispredict_i | input | 1 | Fetch-time prediction was wrong |

## Verification
The bench aims at aliasing: several PCs share each index. A design that compares only the index, or only part of the PC, would send an aliased lookup to another instruction's target. Non-control updates to a live PC catch a table that allocates or retrains on anything. A not-taken miss catches allocation on the wrong direction. Counter walks through both weak states and against both saturation limits catch a wrong initial value or a wrapping counter. Correct-prediction updates that carry a different target catch a design that rewrites the target on every hit. Random traffic with mispredict flags derived from a bench model covers update and lookup arriving in the same cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_TRAIN = 2'd2,
    ACT_FIX   = 2'd3
  } upd_act_e;

  localparam int unsigned PC_BYTE_BITS = 2;

endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CTR_W = 2,
  localparam int unsigned N    = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // lookup read port
  input  logic [IDX_W-1:0] rd0_idx_i,
  output logic             rd0_valid_o,
  output logic [PC_W-1:0]  rd0_tag_o,
  output logic [PC_W-1:0]  rd0_tgt_o,
  output logic [CTR_W-1:0] rd0_ctr_o,
  // update read port
  input  logic [IDX_W-1:0] rd1_idx_i,
  output logic             rd1_valid_o,
  output logic [PC_W-1:0]  rd1_tag_o,
  output logic [CTR_W-1:0] rd1_ctr_o,
  // write port
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_alloc_i,
  input  logic [PC_W-1:0]  wr_tag_i,
  input  logic             wr_tgt_en_i,
  input  logic [PC_W-1:0]  wr_tgt_i,
  input  logic [CTR_W-1:0] wr_ctr_i
);

  logic [N-1:0]     valid_q;
  logic [PC_W-1:0]  tag_q [N];
  logic [PC_W-1:0]  tgt_q [N];
  logic [CTR_W-1:0] ctr_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
      end else if (sel && wr_alloc_i) begin
        valid_q[g] <= 1'b1;
      end
    end

    // payload needs no reset: qualified by valid_q
    always_ff @(posedge clk_i) begin
      if (sel) begin
        ctr_q[g] <= wr_ctr_i;
        if (wr_alloc_i)  tag_q[g] <= wr_tag_i;
        if (wr_tgt_en_i) tgt_q[g] <= wr_tgt_i;
      end
    end
  end

  assign rd0_valid_o = valid_q[rd0_idx_i];
  assign rd0_tag_o   = tag_q[rd0_idx_i];
  assign rd0_tgt_o   = tgt_q[rd0_idx_i];
  assign rd0_ctr_o   = ctr_q[rd0_idx_i];

  assign rd1_valid_o = valid_q[rd1_idx_i];
  assign rd1_tag_o   = tag_q[rd1_idx_i];
  assign rd1_ctr_o   = ctr_q[rd1_idx_i];

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CTR_W = 2
) (
  input  logic [PC_W-1:0]  fetch_pc_i,
  input  logic             ent_valid_i,
  input  logic [PC_W-1:0]  ent_tag_i,
  input  logic [PC_W-1:0]  ent_tgt_i,
  input  logic [CTR_W-1:0] ent_ctr_i,
  output logic             hit_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  npc_o
);

  logic [PC_W-1:0] seq_pc;

  assign seq_pc  = fetch_pc_i + PC_W'(4);
  assign hit_o   = ent_valid_i && (ent_tag_i == fetch_pc_i);
  assign taken_o = hit_o && ent_ctr_i[CTR_W-1];
  assign npc_o   = taken_o ? ent_tgt_i : seq_pc;

endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CTR_W = 2
) (
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_is_ctrl_i,
  input  logic             upd_taken_i,
  input  logic [PC_W-1:0]  upd_target_i,
  input  logic             upd_mispredict_i,
  input  logic             ent_valid_i,
  input  logic [PC_W-1:0]  ent_tag_i,
  input  logic [CTR_W-1:0] ent_ctr_i,
  output logic             wr_en_o,
  output logic             wr_alloc_o,
  output logic [PC_W-1:0]  wr_tag_o,
  output logic             wr_tgt_en_o,
  output logic [PC_W-1:0]  wr_tgt_o,
  output logic [CTR_W-1:0] wr_ctr_o
);

  localparam logic [CTR_W-1:0] CTR_MAX    = '1;
  localparam logic [CTR_W-1:0] CTR_MIN    = '0;
  localparam logic [CTR_W-1:0] CTR_WEAK_T = CTR_W'(1) << (CTR_W - 1);

  upd_act_e         act;
  logic             hit;
  logic [CTR_W-1:0] ctr_next;

  assign hit = ent_valid_i && (ent_tag_i == upd_pc_i);

  always_comb begin
    act = ACT_NONE;
    if (upd_valid_i && upd_is_ctrl_i) begin
      if (hit) act = (upd_mispredict_i && upd_taken_i) ? ACT_FIX : ACT_TRAIN;
      else if (upd_taken_i) act = ACT_ALLOC;
    end
  end

  always_comb begin
    ctr_next = ent_ctr_i;
    if (upd_taken_i) begin
      if (ent_ctr_i != CTR_MAX) ctr_next = ent_ctr_i + CTR_W'(1);
    end else begin
      if (ent_ctr_i != CTR_MIN) ctr_next = ent_ctr_i - CTR_W'(1);
    end
  end

  assign wr_en_o     = (act != ACT_NONE);
  assign wr_alloc_o  = (act == ACT_ALLOC);
  assign wr_tag_o    = upd_pc_i;
  assign wr_tgt_en_o = (act == ACT_ALLOC) || (act == ACT_FIX);
  assign wr_tgt_o    = upd_target_i;
  assign wr_ctr_o    = (act == ACT_ALLOC) ? CTR_WEAK_T : ctr_next;

endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CTR_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic [PC_W-1:0] pred_npc_o,
  output logic            pred_hit_o,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_is_ctrl_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic            upd_mispredict_i
);

  localparam int unsigned IDX_LSB = PC_BYTE_BITS;
  localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [IDX_W-1:0] fetch_idx, upd_idx;
  logic             rd0_valid, rd1_valid;
  logic [PC_W-1:0]  rd0_tag, rd0_tgt, rd1_tag;
  logic [CTR_W-1:0] rd0_ctr, rd1_ctr;
  logic             wr_en, wr_alloc, wr_tgt_en;
  logic [PC_W-1:0]  wr_tag, wr_tgt;
  logic [CTR_W-1:0] wr_ctr;

  assign fetch_idx = fetch_pc_i[IDX_MSB:IDX_LSB];
  assign upd_idx   = upd_pc_i[IDX_MSB:IDX_LSB];

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd0_idx_i   (fetch_idx),
    .rd0_valid_o (rd0_valid),
    .rd0_tag_o   (rd0_tag),
    .rd0_tgt_o   (rd0_tgt),
    .rd0_ctr_o   (rd0_ctr),
    .rd1_idx_i   (upd_idx),
    .rd1_valid_o (rd1_valid),
    .rd1_tag_o   (rd1_tag),
    .rd1_ctr_o   (rd1_ctr),
    .wr_en_i     (wr_en),
    .wr_idx_i    (upd_idx),
    .wr_alloc_i  (wr_alloc),
    .wr_tag_i    (wr_tag),
    .wr_tgt_en_i (wr_tgt_en),
    .wr_tgt_i    (wr_tgt),
    .wr_ctr_i    (wr_ctr)
  );

  btb_lookup #(.PC_W(PC_W), .CTR_W(CTR_W)) u_lookup (
    .fetch_pc_i  (fetch_pc_i),
    .ent_valid_i (rd0_valid),
    .ent_tag_i   (rd0_tag),
    .ent_tgt_i   (rd0_tgt),
    .ent_ctr_i   (rd0_ctr),
    .hit_o       (pred_hit_o),
    .taken_o     (pred_taken_o),
    .npc_o       (pred_npc_o)
  );

  btb_update #(.PC_W(PC_W), .CTR_W(CTR_W)) u_update (
    .upd_valid_i      (upd_valid_i),
    .upd_pc_i         (upd_pc_i),
    .upd_is_ctrl_i    (upd_is_ctrl_i),
    .upd_taken_i      (upd_taken_i),
    .upd_target_i     (upd_target_i),
    .upd_mispredict_i (upd_mispredict_i),
    .ent_valid_i      (rd1_valid),
    .ent_tag_i        (rd1_tag),
    .ent_ctr_i        (rd1_ctr),
    .wr_en_o          (wr_en),
    .wr_alloc_o       (wr_alloc),
    .wr_tag_o         (wr_tag),
    .wr_tgt_en_o      (wr_tgt_en),
    .wr_tgt_o         (wr_tgt),
    .wr_ctr_o         (wr_ctr)
  );

endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic [PC_W-1:0] pred_npc_o,
  input logic            pred_hit_o,
  input logic            pred_taken_o,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_is_ctrl_i,
  input logic            upd_taken_i,
  input logic [PC_W-1:0] upd_target_i,
  input logic            upd_mispredict_i
);

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> pred_hit_o); // R2

  AST_MISS_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> (pred_npc_o == fetch_pc_i + PC_W'(4))); // R3

  AST_NT_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_taken_o |-> (pred_npc_o == fetch_pc_i + PC_W'(4))); // R4

  AST_NONCTRL_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_is_ctrl_i) ##1 $stable(fetch_pc_i)
    |-> ($stable(pred_npc_o) && $stable(pred_hit_o) && $stable(pred_taken_o))); // R5

  AST_ALLOC_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_is_ctrl_i && upd_taken_i && !pred_hit_o && fetch_pc_i == upd_pc_i)
    ##1 $stable(fetch_pc_i)
    |-> (pred_hit_o && pred_taken_o && pred_npc_o == $past(upd_target_i))); // R6

  AST_NT_MISS_NO_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_is_ctrl_i && !upd_taken_i && !pred_hit_o && fetch_pc_i == upd_pc_i)
    ##1 $stable(fetch_pc_i)
    |-> !pred_hit_o); // R7

  AST_GOOD_PRED_KEEPS_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_is_ctrl_i && upd_taken_i && !upd_mispredict_i && pred_taken_o
     && fetch_pc_i == upd_pc_i)
    ##1 $stable(fetch_pc_i)
    |-> (pred_taken_o && $stable(pred_npc_o))); // R10

endmodule

bind btb_top btb_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_btb_top.sv
`timescale 1ns/1ps
module sim_btb_top;

  localparam int unsigned PC_W  = 32;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned N     = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic [PC_W-1:0] pred_npc;
  logic            pred_hit, pred_taken;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_is_ctrl = 1'b0;
  logic            upd_taken = 1'b0;
  logic [PC_W-1:0] upd_target = '0;
  logic            upd_mispredict = 1'b0;

  always #2.5 clk = ~clk;

  btb_top #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(2)) u0 (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .fetch_pc_i       (fetch_pc),
    .pred_npc_o       (pred_npc),
    .pred_hit_o       (pred_hit),
    .pred_taken_o     (pred_taken),
    .upd_valid_i      (upd_valid),
    .upd_pc_i         (upd_pc),
    .upd_is_ctrl_i    (upd_is_ctrl),
    .upd_taken_i      (upd_taken),
    .upd_target_i     (upd_target),
    .upd_mispredict_i (upd_mispredict)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model
  logic            m_v   [N];
  logic [PC_W-1:0] m_tag [N];
  logic [PC_W-1:0] m_tgt [N];
  logic [1:0]      m_ctr [N];

  function automatic int unsigned idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic exp_hit(input logic [PC_W-1:0] pc);
    int unsigned i = idx_of(pc);
    return m_v[i] && (m_tag[i] == pc);
  endfunction

  function automatic logic exp_taken(input logic [PC_W-1:0] pc);
    return exp_hit(pc) && m_ctr[idx_of(pc)][1];
  endfunction

  function automatic logic [PC_W-1:0] exp_npc(input logic [PC_W-1:0] pc);
    return exp_taken(pc) ? m_tgt[idx_of(pc)] : pc + 32'd4;
  endfunction

  task automatic model_apply();
    int unsigned i = idx_of(upd_pc);
    if (!(upd_valid && upd_is_ctrl)) return;
    if (exp_hit(upd_pc)) begin
      if (upd_taken && m_ctr[i] != 2'b11) m_ctr[i] = m_ctr[i] + 2'd1;
      if (!upd_taken && m_ctr[i] != 2'b00) m_ctr[i] = m_ctr[i] - 2'd1;
      if (upd_taken && upd_mispredict) m_tgt[i] = upd_target;
    end else if (upd_taken) begin
      m_v[i] = 1'b1; m_tag[i] = upd_pc; m_tgt[i] = upd_target; m_ctr[i] = 2'b10;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [PC_W-1:0] got,
                     input logic [PC_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // one cycle: drive lookup and update, check lookup, commit update at edge
  task automatic step(input string req, input logic [PC_W-1:0] pc, input logic uv,
                      input logic [PC_W-1:0] upc, input logic ctrl, input logic tk,
                      input logic [PC_W-1:0] tgt, input logic mp);
    @(negedge clk);
    fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_is_ctrl = ctrl;
    upd_taken = tk; upd_target = tgt; upd_mispredict = mp;
    #1;
    chk(req, "npc", pred_npc, exp_npc(pc));
    chk(req, "hit", {31'd0, pred_hit}, {31'd0, exp_hit(pc)});
    chk(req, "taken", {31'd0, pred_taken}, {31'd0, exp_taken(pc)});
    @(posedge clk);
    model_apply();
  endtask

  task automatic look(input string req, input logic [PC_W-1:0] pc);
    step(req, pc, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  localparam logic [PC_W-1:0] PA = 32'h0000_0100;
  localparam logic [PC_W-1:0] PB = 32'h0000_0140; // same index as PA
  localparam logic [PC_W-1:0] T1 = 32'h0000_8000;
  localparam logic [PC_W-1:0] T2 = 32'h0000_9000;

  initial begin
    void'($urandom(32'h5eed_b7b0));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'b00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty table after reset
    look("R1", PA);
    look("R1", PB);
    look("R1", 32'h1234_5678);
    // R3 miss, taken control allocates (R6)
    step("R3", PA, 1'b1, PA, 1'b1, 1'b1, T1, 1'b1);
    // R6 visible; non-control update to PA with other target
    step("R6", PA, 1'b1, PA, 1'b0, 1'b1, T2, 1'b1);
    // R5 nothing changed; not-taken miss for alias PB
    step("R5", PA, 1'b1, PB, 1'b1, 1'b0, T2, 1'b0);
    // R7/R3 PB not allocated, alias of PA misses; PA trained to 11
    step("R7", PB, 1'b1, PA, 1'b1, 1'b1, T1, 1'b0);
    // R2 strong taken; train down to 10
    step("R2", PA, 1'b1, PA, 1'b1, 1'b0, T1, 1'b1);
    // R8 still taken at 10; train down to 01
    step("R8", PA, 1'b1, PA, 1'b1, 1'b0, T1, 1'b1);
    // R4 hit not-taken; taken mispredict with new target -> 10, T2
    step("R4", PA, 1'b1, PA, 1'b1, 1'b1, T2, 1'b1);
    // R9 target replaced; correct-prediction update carrying T1 -> 11, T2 kept
    step("R9", PA, 1'b1, PA, 1'b1, 1'b1, T1, 1'b0);
    // R10 target kept; PB allocates over PA
    step("R10", PA, 1'b1, PB, 1'b1, 1'b1, T1, 1'b1);
    look("R11", PB);
    look("R11", PA);
    // R8 saturation at 00: walk PB down three times then check
    step("R8", PB, 1'b1, PB, 1'b1, 1'b0, T1, 1'b1);
    step("R8", PB, 1'b1, PB, 1'b1, 1'b0, T1, 1'b0);
    step("R8", PB, 1'b1, PB, 1'b1, 1'b0, T1, 1'b0);
    step("R8", PB, 1'b1, PB, 1'b1, 1'b1, T1, 1'b0);
    look("R8", PB);

    // random phase with heavy aliasing
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] fpc, upc, tgt;
      logic ctrl, tk, mp;
      fpc  = 32'h1000 + ($urandom_range(0, 63) << 2);
      upc  = 32'h1000 + ($urandom_range(0, 63) << 2);
      tgt  = 32'h4000 + ($urandom_range(0, 7) << 4);
      ctrl = ($urandom_range(0, 3) != 0);
      tk   = $urandom_range(0, 1)[0];
      mp   = (exp_taken(upc) != tk) || (tk && exp_npc(upc) != tgt);
      step("R2/R3/R8 random", fpc, $urandom_range(0, 4) != 0, upc, ctrl, tk, tgt, mp);
    end

    // R1 again: asynchronous reset clears everything
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    look("R1", PB);
    look("R1", 32'h1000);

    finish_run();
  end

endmodule